// File: doc/BRIEF.md
# LIN Break and Sync-Field Edge Framer

This block sits beside the receiver of a LIN slave port. It resynchronizes the serial input and measures how long the line stays dominant (low). The measure is a count of bit times, taken from a one-cycle tick that the baud generator supplies. A low period of more than eleven bit times is reported as a synchronization break through a sticky flag and an interrupt line. Software acknowledges the flag by strobing a write-one-to-clear input.

A low period that is long enough to corrupt an ordinary character is also flagged early. A one-cycle framing hint fires on the ninth dominant bit time, before the break is recognised. Software that only wants breaks can therefore ignore the receive error path.

Once a break has been seen, the block watches for the sync field that follows. The first falling edge on the line raises a capture-window level. The fifth falling edge, counting that first one, drops it again. A timer capture unit can time-stamp both transitions and derive the master's bit period from them. The window is only re-armed by a later break. Clearing the mode enable stops all counting and drops any armed or open window.

Top module: `lin_break_detect`

## Requirements
- R1: With the mode enabled, a dominant period that spans 12 or more bit ticks sets the break flag on the 12th tick. A period spanning exactly 11 ticks does not set it.
- R2: In every dominant period, the framing hint pulses high for exactly one clock when the 9th bit tick of that period is counted.
- R3: The break flag stays set until a write-one-to-clear strobe arrives. Only that strobe clears it. If a new break and the strobe come in the same cycle, the flag stays set.
- R4: The break interrupt output is high exactly when the break flag is high.
- R5: After a break, the first falling edge on the synchronized input raises the capture window.
- R6: The capture window falls on the fifth falling edge, counting the edge that opened it. Further falling edges have no effect until a new break is detected.
- R7: Any recessive (high) level before the break threshold restarts the dominant-period count. Separate low periods do not add up.
- R8: The dominant-period count saturates. A line stuck low for any length of time produces one framing hint and one break.
- R9: While the mode enable is low, no counting takes place, the window is held low and any armed state is dropped. The break flag keeps its value.
- R10: A new break detected while the window is open closes the window at once and re-arms it for the next sync field.
- R11: After reset the break flag, interrupt, framing hint and capture window are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| linEn | input | 1 | Enables LIN slave break and sync-field detection |
| rxIn | input | 1 | Serial input line (low = dominant) |
| bitTick | input | 1 | One-clock pulse per bit time |
| breakClrWr | input | 1 | Write-one-to-clear strobe for the break flag |
| breakFlag | output | 1 | Sticky break-detected flag |
| breakIrq | output | 1 | Break interrupt request |
| frameErrHint | output | 1 | One-clock pulse at the 9th dominant bit time |
| captureWin | output | 1 | Level framing the sync-field falling edges |

## Verification
The assertions assume that `bitTick` is never high on two consecutive clocks. They also assume that `rxIn` changes far more slowly than the clock, so every level reaches the synchronizer output. The stimulus meets both assumptions. A free-running divider raises the tick once every eight clocks. The line is changed only on tick boundaries and is held for whole bit times, so each held level covers an exact, known number of ticks. The clear strobe is a single-clock pulse driven between clock edges.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_WINDOW = 2'd2
  } syncState_t;

  // control -> datapath
  typedef struct packed {
    logic clrLow;
    logic incLow;
    logic pulseFerr;
    logic setBreak;
    logic clrBreak;
    logic openWin;
    logic closeWin;
    logic incEdge;
    logic clrEdge;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic rxLow;
    logic fallEdge;
    logic lowAtFerr;
    logic lowAtThresh;
    logic lowSat;
    logic edgeLast;
  } dpStatus_t;

endpackage

// File: rtl/lin_brk_datapath.sv
module lin_brk_datapath
  import lin_brk_pkg::*;
#(
  parameter int LOW_THRESH  = 11,
  parameter int FERR_BITS   = 9,
  parameter int SYNC_EDGES  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxIn,
  input  dpStrobe_t  strobe,
  output dpStatus_t  status,
  output logic       breakFlag,
  output logic       frameErrHint,
  output logic       captureWin
);

  localparam int LOW_SAT = LOW_THRESH + 1;
  localparam int CNT_W   = $clog2(LOW_SAT + 1);
  localparam int EDGE_W  = $clog2(SYNC_EDGES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxSync;
  logic                   rxPrev;
  logic [CNT_W-1:0]       lowCnt;
  logic [EDGE_W-1:0]      edgeCnt;

  assign rxSync = syncQ[SYNC_STAGES-1];

  // input resynchronizer, idles recessive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxIn};
      rxPrev <= rxSync;
    end
  end

  // dominant-period counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowCnt <= '0;
    else if (strobe.clrLow)  lowCnt <= '0;
    else if (strobe.incLow)  lowCnt <= lowCnt + 1'b1;
  end

  // sync-field edge counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               edgeCnt <= '0;
    else if (strobe.clrEdge) edgeCnt <= '0;
    else if (strobe.incEdge) edgeCnt <= edgeCnt + 1'b1;
  end

  // flags and window level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakFlag    <= 1'b0;
      frameErrHint <= 1'b0;
      captureWin   <= 1'b0;
    end else begin
      frameErrHint <= strobe.pulseFerr;
      if (strobe.setBreak)      breakFlag <= 1'b1;
      else if (strobe.clrBreak) breakFlag <= 1'b0;
      if (strobe.openWin)       captureWin <= 1'b1;
      else if (strobe.closeWin) captureWin <= 1'b0;
    end
  end

  always_comb begin
    status.rxLow       = ~rxSync;
    status.fallEdge    = rxPrev & ~rxSync;
    status.lowAtFerr   = (lowCnt == CNT_W'(FERR_BITS - 1));
    status.lowAtThresh = (lowCnt == CNT_W'(LOW_THRESH));
    status.lowSat      = (lowCnt == CNT_W'(LOW_SAT));
    status.edgeLast    = (edgeCnt == EDGE_W'(SYNC_EDGES - 1));
  end

  // R8: the counter never passes its saturation value
  p_lowcnt_bounded_r8: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= CNT_W'(LOW_SAT));

  // R6: edge counter stays below the closing count
  p_edge_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt < EDGE_W'(SYNC_EDGES));

  // R2: hint is a single-clock pulse
  p_ferr_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameErrHint |=> !frameErrHint);

  // R3: flag falls only after a clear strobe
  p_clear_only_by_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(breakFlag) |-> $past(strobe.clrBreak));

endmodule

// File: rtl/lin_brk_control.sv
module lin_brk_control
  import lin_brk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      linEn,
  input  logic      bitTick,
  input  logic      breakClrWr,
  input  dpStatus_t status,
  output dpStrobe_t strobe
);

  syncState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;

    if (!linEn) begin
      strobe.clrLow   = 1'b1;
      strobe.closeWin = 1'b1;
      strobe.clrEdge  = 1'b1;
      stateNext       = ST_IDLE;
    end else begin
      // dominant-period measurement
      if (!status.rxLow) begin
        strobe.clrLow = 1'b1;
      end else if (bitTick && !status.lowSat) begin
        strobe.incLow    = 1'b1;
        strobe.pulseFerr = status.lowAtFerr;
        strobe.setBreak  = status.lowAtThresh;
      end

      // sync-field framing
      if (strobe.setBreak) begin
        strobe.closeWin = 1'b1;
        strobe.clrEdge  = 1'b1;
        stateNext       = ST_ARMED;
      end else begin
        unique case (state)
          ST_ARMED: if (status.fallEdge) begin
            strobe.openWin = 1'b1;
            strobe.incEdge = 1'b1;
            stateNext      = ST_WINDOW;
          end
          ST_WINDOW: if (status.fallEdge) begin
            if (status.edgeLast) begin
              strobe.closeWin = 1'b1;
              strobe.clrEdge  = 1'b1;
              stateNext       = ST_IDLE;
            end else begin
              strobe.incEdge = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end

    // a new break takes precedence over the clear strobe
    strobe.clrBreak = breakClrWr & ~strobe.setBreak;
  end

  // R10: a break always leaves the framer armed
  p_break_rearms_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setBreak |=> (state == ST_ARMED));

  // R9: disabled mode returns to idle
  p_disable_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    !linEn |=> (state == ST_IDLE));

  p_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'b11);

endmodule

// File: rtl/lin_break_detect.sv
module lin_break_detect
  import lin_brk_pkg::*;
#(
  parameter int LOW_THRESH  = 11,
  parameter int FERR_BITS   = 9,
  parameter int SYNC_EDGES  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic linEn,
  input  logic rxIn,
  input  logic bitTick,
  input  logic breakClrWr,
  output logic breakFlag,
  output logic breakIrq,
  output logic frameErrHint,
  output logic captureWin
);

  dpStrobe_t strobe;
  dpStatus_t status;

  lin_brk_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .linEn      (linEn),
    .bitTick    (bitTick),
    .breakClrWr (breakClrWr),
    .status     (status),
    .strobe     (strobe)
  );

  lin_brk_datapath #(
    .LOW_THRESH  (LOW_THRESH),
    .FERR_BITS   (FERR_BITS),
    .SYNC_EDGES  (SYNC_EDGES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .rxIn         (rxIn),
    .strobe       (strobe),
    .status       (status),
    .breakFlag    (breakFlag),
    .frameErrHint (frameErrHint),
    .captureWin   (captureWin)
  );

  assign breakIrq = breakFlag;

  // R1: a freshly set flag coincides with a saturated count
  p_break_at_sat_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakFlag) |-> status.lowSat);

  // R5: window opens only on a falling edge
  p_win_opens_on_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(captureWin) |-> $past(status.fallEdge));

  // R9: disabled mode keeps the window low
  p_win_low_disabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    !linEn |=> !captureWin);

endmodule

// File: tb/test_lin_break_detect.sv
`timescale 1ns/1ps
module test_lin_break_detect;

  localparam int EV_FERR = 1;
  localparam int EV_BRK  = 2;
  localparam int EV_CLR  = 3;
  localparam int EV_ON   = 4;
  localparam int EV_OFF  = 5;
  localparam int TICK_DIV = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linEn = 1'b0;
  logic rxIn = 1'b1;
  logic bitTick = 1'b0;
  logic breakClrWr = 1'b0;
  logic breakFlag, breakIrq, frameErrHint, captureWin;

  int checks = 0;
  int fails = 0;
  int expQ[$];
  bit summaryDone = 0;

  lin_break_detect i_lin_break_detect (
    .clk          (clk),
    .rstN         (rstN),
    .linEn        (linEn),
    .rxIn         (rxIn),
    .bitTick      (bitTick),
    .breakClrWr   (breakClrWr),
    .breakFlag    (breakFlag),
    .breakIrq     (breakIrq),
    .frameErrHint (frameErrHint),
    .captureWin   (captureWin)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // bit tick generator, updated just after the rising edge
  initial begin
    int tc = 0;
    forever begin
      @(posedge clk);
      #1;
      tc = (tc + 1) % TICK_DIV;
      bitTick = (tc == 0);
    end
  end

  // monitor: pops expected events as the outputs move
  task automatic observe(input int ev, input string req);
    int e;
    if (expQ.size() == 0) begin
      check(1'b0, req, ev, 0);
    end else begin
      e = expQ.pop_front();
      check(e == ev, req, ev, e);
    end
  endtask

  initial begin
    logic prevBrk = 1'b0;
    logic prevWin = 1'b0;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (frameErrHint)             observe(EV_FERR, "R2");
      if (breakFlag && !prevBrk)    observe(EV_BRK,  "R1");
      if (!breakFlag && prevBrk)    observe(EV_CLR,  "R3");
      if (breakFlag != prevBrk)     check(breakIrq == breakFlag, "R4", breakIrq, breakFlag);
      if (captureWin && !prevWin)   observe(EV_ON,   "R5");
      if (!captureWin && prevWin)   observe(EV_OFF,  "R6");
      prevBrk = breakFlag;
      prevWin = captureWin;
    end
  end

  // hold the line at a level across n bit ticks
  task automatic holdBits(input logic val, input int n);
    while (!bitTick) @(negedge clk);
    rxIn = val;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!bitTick) @(negedge clk);
    end
  endtask

  task automatic syncField(input int nEdges);
    for (int i = 0; i < nEdges; i++) begin
      holdBits(1'b0, 1);
      holdBits(1'b1, 1);
    end
  endtask

  task automatic clearBreak();
    @(negedge clk);
    breakClrWr = 1'b1;
    @(negedge clk);
    breakClrWr = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check(breakFlag == 1'b0,    "R11", breakFlag, 0);
    check(breakIrq == 1'b0,     "R11", breakIrq, 0);
    check(frameErrHint == 1'b0, "R11", frameErrHint, 0);
    check(captureWin == 1'b0,   "R11", captureWin, 0);
    rstN = 1'b1;
    linEn = 1'b1;
    holdBits(1'b1, 3);

    // R1 boundary: 11 ticks low gives only the hint
    expQ.push_back(EV_FERR);
    holdBits(1'b0, 11);
    holdBits(1'b1, 3);
    check(breakFlag == 1'b0, "R1", breakFlag, 0);

    // R1: 12 ticks low is a break
    expQ.push_back(EV_FERR);
    expQ.push_back(EV_BRK);
    holdBits(1'b0, 12);
    holdBits(1'b1, 10);
    check(breakFlag == 1'b1, "R3", breakFlag, 1);

    // R5 R6: window over edges one to five, edges six and seven ignored
    expQ.push_back(EV_ON);
    expQ.push_back(EV_OFF);
    syncField(7);
    holdBits(1'b1, 3);
    check(captureWin == 1'b0, "R6", captureWin, 0);

    expQ.push_back(EV_CLR);
    clearBreak();
    holdBits(1'b1, 2);

    // R7: interrupted low periods do not accumulate
    holdBits(1'b0, 6);
    holdBits(1'b1, 1);
    holdBits(1'b0, 7);
    holdBits(1'b1, 2);
    check(breakFlag == 1'b0, "R7", breakFlag, 0);

    // R8: stuck low gives one hint and one break
    expQ.push_back(EV_FERR);
    expQ.push_back(EV_BRK);
    holdBits(1'b0, 40);
    holdBits(1'b1, 2);
    expQ.push_back(EV_CLR);
    clearBreak();
    holdBits(1'b1, 2);

    // R10: break during an open window closes and rearms it
    expQ.push_back(EV_ON);
    syncField(2);
    check(captureWin == 1'b1, "R10", captureWin, 1);
    expQ.push_back(EV_FERR);
    expQ.push_back(EV_BRK);
    expQ.push_back(EV_OFF);
    holdBits(1'b0, 12);
    holdBits(1'b1, 2);
    expQ.push_back(EV_ON);
    expQ.push_back(EV_OFF);
    syncField(5);
    holdBits(1'b1, 2);
    expQ.push_back(EV_CLR);
    clearBreak();
    holdBits(1'b1, 2);

    // R9: disabling drops the armed state and stops counting
    expQ.push_back(EV_FERR);
    expQ.push_back(EV_BRK);
    holdBits(1'b0, 12);
    holdBits(1'b1, 2);
    linEn = 1'b0;
    holdBits(1'b0, 20);
    holdBits(1'b1, 2);
    syncField(3);
    check(breakFlag == 1'b1, "R9", breakFlag, 1);
    check(captureWin == 1'b0, "R9", captureWin, 0);
    linEn = 1'b1;
    holdBits(1'b1, 2);
    syncField(3);
    check(captureWin == 1'b0, "R9", captureWin, 0);
    expQ.push_back(EV_CLR);
    clearBreak();
    holdBits(1'b1, 3);

    check(expQ.size() == 0, "all", expQ.size(), 0);
    finishRun();
  end

endmodule